// File: doc/BRIEF.md
# Round-Robin TLB Victim Hint

This block supplies a replacement suggestion for a set-associative translation array whose replacement is otherwise chosen by software. It holds one next-victim pointer for the array and a software-visible assist register with two fields: a way-select field and an assist next-victim field. When a lookup misses, the block loads the assist register with the suggested victim way and the way after it. Software may then accept those values or load its own.

An entry write request arrives on a valid/ready stream. The block turns it into a write command on a second valid/ready stream. For the set-associative array, the command carries a way, taken from the way-select field, and a set, taken from a 7-bit field of the effective address (128 sets). When that write is accepted, the assist next-victim field becomes the array's pointer for the next miss. For the fully associative array there is no hint: the entry number is the whole way-select field, and the pointer is left alone.

An invalidate leaves the assist next-victim field with no guaranteed value. A request is accepted when `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high whenever the command slot is empty or is being drained in the same cycle. While `cmd_valid_o` is high and `cmd_ready_i` is low, the command holds still.

Top module: `rr_tlb_victim_hint`

## Requirements
- R1: After reset `hint_way_sel_o` is 0, `hint_nv_o` is 0, `cmd_valid_o` is 0, and the array pointer is 0, so the first miss suggests way 0.
- R2: One cycle after `miss_i`, `hint_way_sel_o` equals the pointer and `hint_nv_o` equals the pointer plus one modulo NWAYS (4 by default, so pointer 3 gives 0).
- R3: One cycle after `sw_ld_i`, both assist fields hold `sw_way_sel_i` and `sw_nv_i`. A software load in the same cycle as a miss wins over the miss.
- R4: An accepted set-associative write (`req_fa_i`=0) produces a command one cycle later. The command has `cmd_fa_o`=0, `cmd_entry_o` equal to the low log2(NWAYS) bits of the way-select field (zero-extended), and `cmd_set_o` equal to `req_ea_i[18:12]` by default (SET_LSB=12). The pointer takes the value of `hint_nv_o`.
- R5: A next-victim value loaded by software and followed by a set-associative write is the way suggested on the next miss.
- R6: An accepted fully associative write (`req_fa_i`=1) gives `cmd_fa_o`=1, `cmd_entry_o` equal to the whole way-select field, and `cmd_set_o`=0. The pointer does not change.
- R7: `req_ready_o` is low while `cmd_valid_o` is high and `cmd_ready_i` is low. During such a stall the command fields stay stable.
- R8: `inval_i` takes priority over a miss or a software load in the same cycle, which are dropped. It leaves `hint_way_sel_o` and the pointer unchanged. `hint_nv_o` is unspecified after an invalidate.
- R9: In a cycle with no miss, load or invalidate, both assist fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_i | input | 1 | Lookup miss in the set-associative array |
| inval_i | input | 1 | Any invalidate, including a flash invalidate |
| sw_ld_i | input | 1 | Software load of the assist register |
| sw_way_sel_i | input | ESEL_W | Way-select value loaded by software |
| sw_nv_i | input | WAY_W | Next-victim value loaded by software |
| req_valid_i | input | 1 | Entry write request valid |
| req_ready_o | output | 1 | Entry write request can be accepted |
| req_fa_i | input | 1 | Request targets the fully associative array |
| req_ea_i | input | EA_W | Effective address of the entry being written |
| cmd_valid_o | output | 1 | Write command valid |
| cmd_ready_i | input | 1 | Write command consumed |
| cmd_fa_o | output | 1 | Command targets the fully associative array |
| cmd_entry_o | output | ESEL_W | Way (set-associative) or entry number (fully associative) |
| cmd_set_o | output | SET_W | Set index, 0 for fully associative writes |
| hint_way_sel_o | output | ESEL_W | Assist way-select field |
| hint_nv_o | output | WAY_W | Assist next-victim field |

## Verification
The round-robin pattern is checked with repeated miss-then-write pairs. These walk the pointer through every way and the wrap from 3 to 0, which catches an off-by-one or a missing modulo. The set field is checked at 0, 127 and mid values, which exposes a field taken at the wrong offset. Software overrides are checked three ways:
- a way-select wider than a way, which tests the truncation;
- a loaded next-victim value, which must reappear on the next miss;
- a fully associative write, which must leave the pointer alone.

Other cases separate the priority order and the stall behaviour: a load and a miss in the same cycle, an invalidate together with a miss, and a held command with a second request waiting.

// File: rtl/rr_hint_pkg.sv
package rr_hint_pkg;
  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_MISS  = 2'd1,
    EV_LOAD  = 2'd2,
    EV_INVAL = 2'd3
  } hint_ev_e;
endpackage

// File: rtl/rr_victim_ptr.sv
module rr_victim_ptr #(
  parameter int WAY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [WAY_W-1:0] upd_val,
  output logic [WAY_W-1:0] ptr_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      ptr_q <= '0;
    else if (upd_en) ptr_q <= upd_val;
  end
endmodule

// File: rtl/rr_assist_reg.sv
module rr_assist_reg
  import rr_hint_pkg::*;
#(
  parameter int NWAYS  = 4,
  parameter int WAY_W  = 2,
  parameter int ESEL_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hint_ev_e          ev,
  input  logic [WAY_W-1:0]  ptr,
  input  logic [ESEL_W-1:0] ld_sel,
  input  logic [WAY_W-1:0]  ld_nv,
  output logic [ESEL_W-1:0] sel_q,
  output logic [WAY_W-1:0]  nv_q
);
  localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NWAYS - 1);

  logic [WAY_W-1:0] ptr_succ;
  assign ptr_succ = (ptr == LAST_WAY) ? '0 : ptr + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
      nv_q  <= '0;
    end else begin
      unique case (ev)
        EV_MISS: begin
          sel_q <= ESEL_W'(ptr);
          nv_q  <= ptr_succ;
        end
        EV_LOAD: begin
          sel_q <= ld_sel;
          nv_q  <= ld_nv;
        end
        EV_INVAL: nv_q <= ptr;  // value carries no guarantee
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rr_wr_stage.sv
module rr_wr_stage #(
  parameter int ESEL_W = 4,
  parameter int SET_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_fa,
  input  logic [ESEL_W-1:0] in_entry,
  input  logic [SET_W-1:0]  in_set,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_fa,
  output logic [ESEL_W-1:0] out_entry,
  output logic [SET_W-1:0]  out_set
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_fa    <= 1'b0;
      out_entry <= '0;
      out_set   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_fa    <= in_fa;
        out_entry <= in_entry;
        out_set   <= in_set;
      end
    end
  end
endmodule

// File: rtl/rr_tlb_victim_hint.sv
module rr_tlb_victim_hint
  import rr_hint_pkg::*;
#(
  parameter int NWAYS      = 4,
  parameter int FA_ENTRIES = 16,
  parameter int EA_W       = 32,
  parameter int SET_W      = 7,
  parameter int SET_LSB    = 12,
  localparam int WAY_W     = $clog2(NWAYS),
  localparam int FA_W      = $clog2(FA_ENTRIES),
  localparam int ESEL_W    = (FA_W > WAY_W) ? FA_W : WAY_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_i,
  input  logic              inval_i,
  input  logic              sw_ld_i,
  input  logic [ESEL_W-1:0] sw_way_sel_i,
  input  logic [WAY_W-1:0]  sw_nv_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_fa_i,
  input  logic [EA_W-1:0]   req_ea_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic              cmd_fa_o,
  output logic [ESEL_W-1:0] cmd_entry_o,
  output logic [SET_W-1:0]  cmd_set_o,
  output logic [ESEL_W-1:0] hint_way_sel_o,
  output logic [WAY_W-1:0]  hint_nv_o
);
  hint_ev_e          ev;
  logic [WAY_W-1:0]  ptr_q;
  logic              fire;
  logic              sa_fire;
  logic [ESEL_W-1:0] entry_sel;
  logic [SET_W-1:0]  set_sel;
  logic              unused_ea;

  assign unused_ea = ^req_ea_i;

  always_comb begin
    if (inval_i)      ev = EV_INVAL;
    else if (sw_ld_i) ev = EV_LOAD;
    else if (miss_i)  ev = EV_MISS;
    else              ev = EV_NONE;
  end

  assign fire    = req_valid_i && req_ready_o;
  assign sa_fire = fire && !req_fa_i;

  assign entry_sel = req_fa_i ? hint_way_sel_o : ESEL_W'(hint_way_sel_o[WAY_W-1:0]);
  assign set_sel   = req_fa_i ? '0 : req_ea_i[SET_LSB +: SET_W];

  rr_victim_ptr #(.WAY_W(WAY_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (sa_fire),
    .upd_val (hint_nv_o),
    .ptr_q   (ptr_q)
  );

  rr_assist_reg #(.NWAYS(NWAYS), .WAY_W(WAY_W), .ESEL_W(ESEL_W)) u_assist (
    .clk    (clk),
    .rst_n  (rst_n),
    .ev     (ev),
    .ptr    (ptr_q),
    .ld_sel (sw_way_sel_i),
    .ld_nv  (sw_nv_i),
    .sel_q  (hint_way_sel_o),
    .nv_q   (hint_nv_o)
  );

  rr_wr_stage #(.ESEL_W(ESEL_W), .SET_W(SET_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid_i),
    .in_ready  (req_ready_o),
    .in_fa     (req_fa_i),
    .in_entry  (entry_sel),
    .in_set    (set_sel),
    .out_valid (cmd_valid_o),
    .out_ready (cmd_ready_i),
    .out_fa    (cmd_fa_o),
    .out_entry (cmd_entry_o),
    .out_set   (cmd_set_o)
  );
endmodule

// File: rtl/rr_tlb_victim_hint_chk.sv
module rr_tlb_victim_hint_chk #(
  parameter int NWAYS   = 4,
  parameter int EA_W    = 32,
  parameter int SET_W   = 7,
  parameter int SET_LSB = 12,
  parameter int WAY_W   = 2,
  parameter int ESEL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_i,
  input logic              inval_i,
  input logic              sw_ld_i,
  input logic [ESEL_W-1:0] sw_way_sel_i,
  input logic [WAY_W-1:0]  sw_nv_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              req_fa_i,
  input logic [EA_W-1:0]   req_ea_i,
  input logic              cmd_valid_o,
  input logic              cmd_ready_i,
  input logic              cmd_fa_o,
  input logic [ESEL_W-1:0] cmd_entry_o,
  input logic [SET_W-1:0]  cmd_set_o,
  input logic [ESEL_W-1:0] hint_way_sel_o,
  input logic [WAY_W-1:0]  hint_nv_o,
  input logic [WAY_W-1:0]  arr_ptr
);
  localparam logic [WAY_W-1:0] TOP_WAY = WAY_W'(NWAYS - 1);

  assert_miss_hint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_i && !sw_ld_i && !inval_i) |=>
      (hint_way_sel_o == ESEL_W'($past(arr_ptr))) &&
      (hint_nv_o == (($past(arr_ptr) == TOP_WAY) ? '0 : $past(arr_ptr) + 1'b1)));

  assert_sw_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_ld_i && !inval_i) |=>
      (hint_way_sel_o == $past(sw_way_sel_i)) && (hint_nv_o == $past(sw_nv_i)));

  assert_sa_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && !req_fa_i) |=>
      cmd_valid_o && !cmd_fa_o &&
      (cmd_entry_o == ESEL_W'($past(hint_way_sel_o[WAY_W-1:0]))) &&
      (cmd_set_o == $past(req_ea_i[SET_LSB +: SET_W])) &&
      (arr_ptr == $past(hint_nv_o)));

  assert_fa_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && req_fa_i) |=>
      cmd_valid_o && cmd_fa_o && (cmd_entry_o == $past(hint_way_sel_o)) &&
      (cmd_set_o == '0) && $stable(arr_ptr));

  assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=>
      cmd_valid_o && $stable(cmd_fa_o) && $stable(cmd_entry_o) && $stable(cmd_set_o));

  assert_stall_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |-> !req_ready_o);

  assert_inval_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inval_i && !(req_valid_i && req_ready_o)) |=>
      $stable(hint_way_sel_o) && $stable(arr_ptr));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_i && !sw_ld_i && !inval_i) |=>
      $stable(hint_way_sel_o) && $stable(hint_nv_o));
endmodule

bind rr_tlb_victim_hint rr_tlb_victim_hint_chk #(
  .NWAYS(NWAYS), .EA_W(EA_W), .SET_W(SET_W), .SET_LSB(SET_LSB),
  .WAY_W(WAY_W), .ESEL_W(ESEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .inval_i(inval_i),
  .sw_ld_i(sw_ld_i), .sw_way_sel_i(sw_way_sel_i), .sw_nv_i(sw_nv_i),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_fa_i(req_fa_i),
  .req_ea_i(req_ea_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
  .cmd_fa_o(cmd_fa_o), .cmd_entry_o(cmd_entry_o), .cmd_set_o(cmd_set_o),
  .hint_way_sel_o(hint_way_sel_o), .hint_nv_o(hint_nv_o), .arr_ptr(ptr_q)
);

// File: tb/test_rr_tlb_victim_hint.sv
module test_rr_tlb_victim_hint;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       miss_i = 0, inval_i = 0, sw_ld_i = 0;
  logic [3:0] sw_way_sel_i = '0;
  logic [1:0] sw_nv_i = '0;
  logic       req_valid_i = 0, req_fa_i = 0, cmd_ready_i = 1;
  logic [31:0] req_ea_i = '0;
  logic       req_ready_o, cmd_valid_o, cmd_fa_o;
  logic [3:0] cmd_entry_o, hint_way_sel_o;
  logic [6:0] cmd_set_o;
  logic [1:0] hint_nv_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rr_tlb_victim_hint i_rr_tlb_victim_hint (
    .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .inval_i(inval_i),
    .sw_ld_i(sw_ld_i), .sw_way_sel_i(sw_way_sel_i), .sw_nv_i(sw_nv_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_fa_i(req_fa_i),
    .req_ea_i(req_ea_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_fa_o(cmd_fa_o), .cmd_entry_o(cmd_entry_o), .cmd_set_o(cmd_set_o),
    .hint_way_sel_o(hint_way_sel_o), .hint_nv_o(hint_nv_o)
  );

  // vector: op[25:24] sel[23:20] nv[19:18] set[17:11] expA[10:7] expB[6:0]
  // op 0 miss, 1 software load, 2 set-assoc write, 3 fully-assoc write
  // miss/load check hint (A=way_sel, B=nv); writes check cmd (A=entry, B=set)
  localparam int NV = 15;
  localparam logic [25:0] VEC [NV] = '{
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd0,  7'd1},
    {2'd2, 4'd0,  2'd0, 7'd5,   4'd0,  7'd5},
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd1,  7'd2},
    {2'd2, 4'd0,  2'd0, 7'd127, 4'd1,  7'd127},
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd2,  7'd3},
    {2'd2, 4'd0,  2'd0, 7'd0,   4'd2,  7'd0},
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd3,  7'd0},
    {2'd2, 4'd0,  2'd0, 7'd64,  4'd3,  7'd64},
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd0,  7'd1},
    {2'd1, 4'd9,  2'd2, 7'd0,   4'd9,  7'd2},
    {2'd2, 4'd0,  2'd0, 7'd3,   4'd1,  7'd3},
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd2,  7'd3},
    {2'd1, 4'd13, 2'd0, 7'd0,   4'd13, 7'd0},
    {2'd3, 4'd0,  2'd0, 7'd99,  4'd13, 7'd0},
    {2'd0, 4'd0,  2'd0, 7'd0,   4'd2,  7'd3}
  };
  localparam string TAGS [NV] = '{"R1 R2", "R4", "R2", "R4", "R2", "R4", "R2",
    "R4", "R2", "R3", "R4", "R5", "R3", "R6", "R6"};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 way_sel", hint_way_sel_o, 0);
    check("R1 nv", hint_nv_o, 0);
    check("R1 cmd_valid", cmd_valid_o, 0);
    check("R1 ready", req_ready_o, 1);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      case (v[25:24])
        2'd0: miss_i = 1;
        2'd1: begin sw_ld_i = 1; sw_way_sel_i = v[23:20]; sw_nv_i = v[19:18]; end
        default: begin
          req_valid_i = 1;
          req_fa_i = v[24];
          req_ea_i = 32'h5A5A_5A5A;
          req_ea_i[18:12] = v[17:11];
        end
      endcase
      step();
      miss_i = 0; sw_ld_i = 0; req_valid_i = 0;
      if (v[25]) begin
        check({TAGS[i], " cmd_valid"}, cmd_valid_o, 1);
        check({TAGS[i], " cmd_fa"}, cmd_fa_o, v[24]);
        check({TAGS[i], " entry"}, cmd_entry_o, v[10:7]);
        check({TAGS[i], " set"}, cmd_set_o, v[6:0]);
      end else begin
        check({TAGS[i], " way_sel"}, hint_way_sel_o, v[10:7]);
        check({TAGS[i], " nv"}, hint_nv_o, v[6:0]);
      end
    end
    step();

    // R9 idle: fields hold (way_sel 2, nv 3)
    repeat (3) step();
    check("R9 way_sel", hint_way_sel_o, 2);
    check("R9 nv", hint_nv_o, 3);

    // R3 load beats miss in the same cycle
    sw_ld_i = 1; miss_i = 1; sw_way_sel_i = 4'd10; sw_nv_i = 2'd0;
    step();
    sw_ld_i = 0; miss_i = 0;
    check("R3 same-cycle way_sel", hint_way_sel_o, 10);
    check("R3 same-cycle nv", hint_nv_o, 0);

    // set pointer to 1 via load + SA write, then miss
    sw_ld_i = 1; sw_way_sel_i = 4'd5; sw_nv_i = 2'd1;
    step(); sw_ld_i = 0;
    req_valid_i = 1; req_fa_i = 0; req_ea_i = 32'h0000_7000;
    step(); req_valid_i = 0;
    check("R4 entry truncation", cmd_entry_o, 1);
    check("R4 set", cmd_set_o, 7);
    miss_i = 1; step(); miss_i = 0;
    check("R5 way_sel", hint_way_sel_o, 1);

    // R8 invalidate drops a same-cycle miss, keeps way_sel and pointer
    sw_ld_i = 1; sw_way_sel_i = 4'd6; sw_nv_i = 2'd3;
    step(); sw_ld_i = 0;
    inval_i = 1; miss_i = 1;
    step(); inval_i = 0; miss_i = 0;
    check("R8 way_sel kept", hint_way_sel_o, 6);
    miss_i = 1; step(); miss_i = 0;
    check("R8 pointer kept", hint_way_sel_o, 1);
    check("R8 miss after inval nv", hint_nv_o, 2);

    // R7 back-pressure
    cmd_ready_i = 0;
    req_valid_i = 1; req_fa_i = 0; req_ea_i = 32'h0000_9000;
    step();
    req_ea_i = 32'h0001_4000;  // second request waits, set 20
    check("R7 cmd_valid", cmd_valid_o, 1);
    check("R7 ready low", req_ready_o, 0);
    repeat (3) step();
    check("R7 held entry", cmd_entry_o, 1);
    check("R7 held set", cmd_set_o, 9);
    check("R7 still valid", cmd_valid_o, 1);
    cmd_ready_i = 1;
    #1;
    check("R7 ready on drain", req_ready_o, 1);
    step();
    req_valid_i = 0;
    check("R7 second set", cmd_set_o, 20);
    check("R7 second entry", cmd_entry_o, 1);
    step();
    check("R7 drained", cmd_valid_o, 0);

    done = 1;
    finish_run();
  end
endmodule